// File: doc/BRIEF.md
# Critical-Mode Totem-Pole Gate Sequencer

This block produces the gate drives for one half-bridge phase of a totem-pole boost rectifier running in critical conduction. It also produces the two slow line-frequency switch drives. A switching cycle has four parts. The control switch is held on for a programmed time. After a dead time, the synchronous rectifier conducts until the inductor current reaches zero. The rectifier may then stay on for a programmed extension, which drives the current slightly negative. A resonant dead time follows, and the next turn-on then lands at zero voltage.

The line-polarity input decides which fast switch plays which role, and which line switch is on. A polarity change is taken only between switching cycles, behind an extra all-off interval. The on-time word comes from an outside table, indexed by position within the half-line period. The extension word is zero wherever plain valley switching is wanted. Both words are sampled per cycle. A zero-current comparator bit, already synchronous to the comparator's own logic, enters through a two-flop synchronizer. The block ignores it during a short blanking window. If no zero crossing arrives, a timeout ends rectifier conduction and raises a one-clock fault.

Top module: `crm_gate_seq`

## Requirements
- R1: With `line_pos`=1 the control role is on `gate_lo` and the rectifier role on `gate_hi`, with `line_a`=1 and `line_b`=0. With `line_pos`=0 the roles of `gate_lo` and `gate_hi` are exchanged, with `line_a`=0 and `line_b`=1.
- R2: Each control pulse lasts exactly `ton_word` clocks, or 1 clock when `ton_word` is 0. The word is sampled on the edge that starts the pulse.
- R3: Between control turn-off and rectifier turn-on, both fast gates stay low for exactly DEAD clocks. Between rectifier turn-off and the next control turn-on they also stay low for exactly DEAD clocks. The two fast gates are never high together.
- R4: `zcd_raw` passes through two synchronizer flops. A zero crossing is acted on at the third rising edge after `zcd_raw` goes high, so the rectifier has conducted K+2 clocks when it is first seen high after K clocks of conduction.
- R5: On an accepted zero crossing, the rectifier stays on for `ext_word` more clocks, sampled at that edge. A value of 0 turns the rectifier off at once.
- R6: `zcd_raw` is ignored during the first BLANK clocks of rectifier conduction, so conduction lasts at least BLANK clocks. A pulse that lies wholly inside the window has no effect.
- R7: When TMO clocks of conduction pass without an accepted zero crossing, the rectifier turns off with no extension. `zcd_fault` is then high for exactly one clock: the first clock with the rectifier off. At all other times `zcd_fault` is low.
- R8: A change of `line_pos` is acted on only at the end of the resonant dead time. The fast gates then stay low for a further DEAD clocks, so the gap totals 2*DEAD. `line_a`/`line_b` switch on the same edge as the first control pulse under the new roles. They do not change at any other time while enabled.
- R9: While `en` is low, all four gate outputs and the line outputs are low in the same clock. After `en` rises, the fast gates stay low for DEAD clocks before the first control pulse. The line outputs then take the current polarity directly.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces every gate off |
| line_pos | input | 1 | Line polarity, 1 = positive half-cycle |
| zcd_raw | input | 1 | Zero-current comparator bit, high once current has crossed zero |
| ton_word | input | TW | Control on-time in clocks for the coming cycle |
| ext_word | input | TW | Rectifier extension in clocks after the zero crossing |
| gate_lo | output | 1 | Bottom fast switch gate |
| gate_hi | output | 1 | Top fast switch gate |
| line_a | output | 1 | Line switch on during positive half-cycles |
| line_b | output | 1 | Line switch on during negative half-cycles |
| zcd_fault | output | 1 | One-clock pulse when rectifier conduction timed out |

## Verification
The assertions assume several things about the inputs. `ton_word` and `ext_word` are meaningful only at the edge that samples them, and nothing else reads them. The zero-current bit is taken to rise at most once per rectifier interval, apart from deliberate glitches. The bench acts as a model of the power stage. It raises `zcd_raw` a chosen number of clocks after it sees the rectifier gate rise, and clears it once the gate falls. It changes `line_pos` and the time words only when the rectifier has just turned off. It keeps the zero-crossing delay well inside the timeout, except where the timeout is the case under test.

// File: rtl/crm_seq_pkg.sv
package crm_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RES_DT = 3'd1,
    ST_CTRL   = 3'd2,
    ST_CS_DT  = 3'd3,
    ST_SR     = 3'd4,
    ST_SR_EXT = 3'd5,
    ST_SWAP   = 3'd6
  } crm_state_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/crm_zcd_sync.sv
module crm_zcd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/crm_seq_fsm.sv
module crm_seq_fsm
  import crm_seq_pkg::*;
#(
  parameter int TW    = 8,
  parameter int DEAD  = 4,
  parameter int BLANK = 6,
  parameter int TMO   = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          line_pos,
  input  logic          zcd_s,
  input  logic [TW-1:0] ton_word,
  input  logic [TW-1:0] ext_word,
  output logic          ctrl_req,
  output logic          sr_req,
  output logic          run,
  output logic          pol,
  output logic          fault
);

  localparam int CW = max_u(TW, $clog2(TMO + 1)) + 1;
  localparam logic [CW-1:0] DEAD_LD  = CW'(DEAD - 1);
  localparam logic [CW-1:0] BLANK_LIM = CW'(BLANK - 1);
  localparam logic [CW-1:0] TMO_LIM  = CW'(TMO - 1);

  crm_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          pol_q, pol_n;
  logic          flt_q, flt_n;
  logic [CW-1:0] ton_ld, ext_ld;
  logic          zc_ok;

  assign ton_ld = (ton_word == '0) ? '0 : CW'(ton_word) - CW'(1);
  assign ext_ld = CW'(ext_word) - CW'(1);
  assign zc_ok  = zcd_s && (cnt_q >= BLANK_LIM);

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    pol_n = pol_q;
    flt_n = 1'b0;
    if (!en) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_n  = ST_RES_DT;
          cnt_n = DEAD_LD;
          pol_n = line_pos;
        end
        ST_RES_DT: begin
          if (cnt_q == '0) begin
            if (line_pos != pol_q) begin
              st_n  = ST_SWAP;
              cnt_n = DEAD_LD;
            end else begin
              st_n  = ST_CTRL;
              cnt_n = ton_ld;
            end
          end else begin
            cnt_n = cnt_q - CW'(1);
          end
        end
        ST_SWAP: begin
          if (cnt_q == '0) begin
            st_n  = ST_CTRL;
            cnt_n = ton_ld;
            pol_n = line_pos;
          end else begin
            cnt_n = cnt_q - CW'(1);
          end
        end
        ST_CTRL: begin
          if (cnt_q == '0) begin
            st_n  = ST_CS_DT;
            cnt_n = DEAD_LD;
          end else begin
            cnt_n = cnt_q - CW'(1);
          end
        end
        ST_CS_DT: begin
          if (cnt_q == '0) begin
            st_n  = ST_SR;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_q - CW'(1);
          end
        end
        ST_SR: begin
          if (zc_ok) begin
            if (ext_word == '0) begin
              st_n  = ST_RES_DT;
              cnt_n = DEAD_LD;
            end else begin
              st_n  = ST_SR_EXT;
              cnt_n = ext_ld;
            end
          end else if (cnt_q == TMO_LIM) begin
            st_n  = ST_RES_DT;
            cnt_n = DEAD_LD;
            flt_n = 1'b1;
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        ST_SR_EXT: begin
          if (cnt_q == '0) begin
            st_n  = ST_RES_DT;
            cnt_n = DEAD_LD;
          end else begin
            cnt_n = cnt_q - CW'(1);
          end
        end
        default: begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      pol_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      pol_q <= pol_n;
      flt_q <= flt_n;
    end
  end

  assign ctrl_req = (st_q == ST_CTRL);
  assign sr_req   = (st_q == ST_SR) || (st_q == ST_SR_EXT);
  assign run      = (st_q != ST_IDLE);
  assign pol      = pol_q;
  assign fault    = flt_q;

  // R6: no exit from conduction while the blanking window is open
  a_r6_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SR && cnt_q < BLANK_LIM && en) |=> (st_q == ST_SR));

  // R7: the fault pulse only follows rectifier conduction
  a_r7_fault_source: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |-> ($past(st_q) == ST_SR));

  // R8: polarity register moves only out of the swap gap or on start-up
  a_r8_pol_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_q != $past(pol_q)) |-> ($past(st_q) == ST_SWAP || $past(st_q) == ST_IDLE));

  // R9: a low enable sends the sequencer to idle on the next edge
  a_r9_idle_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st_q == ST_IDLE));

  // R3: the control pulse is always entered from an all-off interval
  a_r3_ctrl_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_CTRL) |-> ($past(st_q) == ST_RES_DT || $past(st_q) == ST_SWAP));

endmodule

// File: rtl/crm_role_map.sv
module crm_role_map (
  input  logic en,
  input  logic run,
  input  logic pol,
  input  logic ctrl_req,
  input  logic sr_req,
  output logic gate_lo,
  output logic gate_hi,
  output logic line_a,
  output logic line_b
);

  logic act;

  assign act     = en && run;
  assign gate_lo = act && (pol ? ctrl_req : sr_req);
  assign gate_hi = act && (pol ? sr_req : ctrl_req);
  assign line_a  = act && pol;
  assign line_b  = act && !pol;

endmodule

// File: rtl/crm_gate_seq.sv
module crm_gate_seq #(
  parameter int TW    = 8,
  parameter int DEAD  = 4,
  parameter int BLANK = 6,
  parameter int TMO   = 64,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          line_pos,
  input  logic          zcd_raw,
  input  logic [TW-1:0] ton_word,
  input  logic [TW-1:0] ext_word,
  output logic          gate_lo,
  output logic          gate_hi,
  output logic          line_a,
  output logic          line_b,
  output logic          zcd_fault
);

  logic zcd_s, ctrl_req, sr_req, run, pol;

  crm_zcd_sync #(.STAGES(SYNC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (zcd_raw),
    .sync_out (zcd_s)
  );

  crm_seq_fsm #(.TW(TW), .DEAD(DEAD), .BLANK(BLANK), .TMO(TMO)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .line_pos (line_pos),
    .zcd_s    (zcd_s),
    .ton_word (ton_word),
    .ext_word (ext_word),
    .ctrl_req (ctrl_req),
    .sr_req   (sr_req),
    .run      (run),
    .pol      (pol),
    .fault    (zcd_fault)
  );

  crm_role_map u_map (
    .en       (en),
    .run      (run),
    .pol      (pol),
    .ctrl_req (ctrl_req),
    .sr_req   (sr_req),
    .gate_lo  (gate_lo),
    .gate_hi  (gate_hi),
    .line_a   (line_a),
    .line_b   (line_b)
  );

  // R3: shoot-through never occurs at the pins
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_lo && gate_hi));

  // R1: exactly one line switch is on whenever a fast gate is on
  a_r1_line_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_lo || gate_hi) |-> (line_a != line_b));

  // R7: timeout never coincides with a conducting rectifier
  a_r7_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    zcd_fault |-> !(gate_lo || gate_hi));

endmodule

// File: tb/tb_crm_gate_seq.sv
module tb_crm_gate_seq;
  localparam int TW = 8, DEAD = 4, BLANK = 6, TMO = 64;

  logic clk = 1'b0;
  logic rst_n, en, line_pos, zcd;
  logic [TW-1:0] ton_w, ext_w;
  logic gate_lo, gate_hi, line_a, line_b, zcd_fault;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  crm_gate_seq #(.TW(TW), .DEAD(DEAD), .BLANK(BLANK), .TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .line_pos(line_pos), .zcd_raw(zcd),
    .ton_word(ton_w), .ext_word(ext_w), .gate_lo(gate_lo), .gate_hi(gate_hi),
    .line_a(line_a), .line_b(line_b), .zcd_fault(zcd_fault)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic gate(bit hi);
    return hi ? gate_hi : gate_lo;
  endfunction

  function automatic int exp_ctrl(int t);
    return (t == 0) ? 1 : t;
  endfunction

  function automatic int exp_sr(int k, int e);
    int r;
    if (k == 0) return TMO;
    r = (k + 2 < BLANK) ? BLANK : k + 2;
    if (r > TMO) return TMO;
    return r + e;
  endfunction

  // One switching cycle seen from the pins; bench plays the power stage.
  task automatic run_cycle(int t, int e, int k, bit pos, bit old_pos, int exp_gap, bit glitch);
    bit c_hi;
    int gap, len, dead, sr, guard;
    c_hi = !pos;
    ton_w = TW'(t);
    ext_w = TW'(e);
    zcd = 1'b0;
    gap = 0; len = 0; dead = 0; sr = 0; guard = 0;
    while (!gate(c_hi) && guard < 1000) begin
      chk(!gate_lo && !gate_hi, "R3 gap fast gates low", int'(gate_lo | gate_hi), 0);
      chk(line_a == old_pos && line_b == !old_pos, "R8 line hold in gap", int'(line_a), int'(old_pos));
      if (gap >= 1) chk(!zcd_fault, "R7 fault one clock", int'(zcd_fault), 0);
      gap++; guard++;
      @(negedge clk);
    end
    chk(gap == exp_gap, "R3/R8 dead gap before control", gap, exp_gap);
    while (gate(c_hi) && guard < 2000) begin
      chk(!gate(!c_hi), "R1 rectifier low during control", int'(gate(!c_hi)), 0);
      chk(line_a == pos && line_b == !pos, "R1 line switches", int'(line_a), int'(pos));
      len++; guard++;
      @(negedge clk);
    end
    chk(len == exp_ctrl(t), "R2 control width", len, exp_ctrl(t));
    while (!gate(!c_hi) && guard < 3000) begin
      chk(!gate(c_hi), "R3 control low in dead", int'(gate(c_hi)), 0);
      dead++; guard++;
      @(negedge clk);
    end
    chk(dead == DEAD, "R3 control-to-rectifier dead", dead, DEAD);
    while (gate(!c_hi) && guard < 4000) begin
      chk(!gate(c_hi) && !zcd_fault, "R1 control low during rectifier", int'(gate(c_hi)), 0);
      chk(line_a == pos, "R1 line during rectifier", int'(line_a), int'(pos));
      sr++; guard++;
      if (glitch && sr == 1) zcd = 1'b1;
      if (glitch && sr == 2) zcd = 1'b0;
      if (k != 0 && sr == k) zcd = 1'b1;
      @(negedge clk);
    end
    zcd = 1'b0;
    chk(sr == exp_sr(k, e), "R4/R5/R6/R7 rectifier width", sr, exp_sr(k, e));
    chk(zcd_fault == (k == 0), "R7 fault on timeout only", int'(zcd_fault), int'(k == 0));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit p, np;
    int guard;
    void'($urandom(32'd2718));
    rst_n = 1'b0; en = 1'b0; line_pos = 1'b1; zcd = 1'b0; ton_w = '0; ext_w = '0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk({gate_lo, gate_hi, line_a, line_b, zcd_fault} == 5'b0, "R10 reset outputs low",
        int'({gate_lo, gate_hi, line_a, line_b, zcd_fault}), 0);
    en = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk({gate_lo, gate_hi, line_a, line_b} == 4'b0, "R9 disabled outputs low",
        int'({gate_lo, gate_hi, line_a, line_b}), 0);
    en = 1'b1;
    @(negedge clk);

    run_cycle(10, 0, 8, 1, 1, DEAD, 0);      // R1 R4 valley switching
    run_cycle(0, 5, 15, 1, 1, DEAD, 0);      // R2 zero on-time, R5 extension
    run_cycle(20, 3, 1, 1, 1, DEAD, 0);      // R6 early crossing blanked
    run_cycle(12, 0, 20, 1, 1, DEAD, 1);     // R6 glitch inside window ignored
    run_cycle(8, 7, 0, 1, 1, DEAD, 0);       // R7 timeout, extension skipped
    line_pos = 1'b0;
    run_cycle(9, 2, 10, 0, 1, 2 * DEAD, 0);  // R8 swap, R1 negative roles
    run_cycle(255, 4, 5, 0, 0, DEAD, 0);     // R2 largest on-time

    // R9: drop enable in the middle of a control pulse
    guard = 0;
    while (!gate_hi && guard < 100) begin guard++; @(negedge clk); end
    en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk({gate_lo, gate_hi, line_a, line_b, zcd_fault} == 5'b0, "R9 disable forces low",
          int'({gate_lo, gate_hi, line_a, line_b, zcd_fault}), 0);
      @(negedge clk);
    end
    line_pos = 1'b1;
    en = 1'b1;
    @(negedge clk);
    run_cycle(6, 0, 4, 1, 1, DEAD, 0);       // R9 restart with new polarity, no swap gap

    p = 1'b1;
    for (int n = 0; n < 60; n++) begin
      int t, e, k;
      t = int'($urandom_range(0, 60));
      e = ($urandom_range(0, 1) == 0) ? 0 : int'($urandom_range(1, 15));
      k = int'($urandom_range(1, 40));
      np = ($urandom_range(0, 99) < 15) ? !p : p;
      line_pos = np;
      run_cycle(t, e, k, np, p, (np != p) ? 2 * DEAD : DEAD, 0);
      p = np;
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule